// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Aggregator

The aggregator collects 112 raw interrupt lines, latches a pending flag on each rising edge and gates it with a per-source mask. It reports the combined result to a host on one active-high interrupt line. Sources are grouped into 14 blocks of 8 lines. Each block reduces to one summary bit. Blocks are split across two master summary registers of seven blocks each, and the second master is folded into the first, so the host finds any pending source by walking master 0, then a master 1 if flagged, then a block.

All control goes through a byte-wide synchronous register port with 16-bit addresses. Some write-only clear registers share an address with the neighbouring block's read-only root register. The same address therefore means different things for a read and for a write.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every pending flag is clear, every mask bit reads 1 (mask registers read 0xFF) and `irq_o` is 0.
- R2: A 0-to-1 transition of a source sampled on consecutive clock edges sets that source's pending flag. The flag stays set after the source returns to 0, until it is cleared.
- R3: The root register of block b (1..7) of master m reads at master address + b. Each bit reads pending AND NOT mask.
- R4: The mask register of block b is written and read at master address + b + 8. Writing 1 to a bit masks the source and writing 0 unmasks it. A flag that is already pending shows in the root as soon as its source is unmasked.
- R5: Writing to master address + b + 1 clears the pending flags of block b wherever the written bit is 1, and leaves flags whose written bit is 0 unchanged. A new rising edge in the same cycle as its clear leaves the flag set.
- R6: The real-time register of block b at master address + b + 15 returns the present source levels, whatever the pending and mask state.
- R7: Master 1 sits at 0x1B0. Bit b (1..7) is the OR of block b's root bits in master 1, and bit 0 reads 0.
- R8: Master 0 sits at 0x130. Bits 7:1 summarise its blocks 1..7, and bit 0 is 1 whenever any bit of master 1 is 1.
- R9: `irq_o` is the OR of the master 0 bits, taken through one register. It changes on the clock edge after the edge that changed a pending flag or mask.
- R10: Writes to root-only, master, real-time or unmapped addresses change no pending flag or mask.
- R11: Source n belongs to global block g = n/8, bit n%8. Its master is g/7 and its local block number is g%7 + 1.
- R12: A read strobe loads `rdata_o` on the next edge, and `rdata_o` holds while no read is strobed. Unmapped addresses, including the write-only clear address of block 7 (master address + 8), read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 112 | Raw interrupt lines, synchronous to clk_i |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Summary interrupt to host |

## Verification
Every one of the 112 sources is raised on its own, so each one is the only input. This shows the source-to-block-to-master mapping, the chaining of master 1 into bit 0 of master 0, and the one-cycle lag of `irq_o`. Each source is then lowered and cleared, first with an inverted clear pattern and then with its own bit, which separates selective clearing from whole-register clearing. Directed patterns cover the rest: edges that arrive while masked, unmasking after latching, an edge coinciding with its clear, and writes to the root address that aliases the previous block's clear. Together they separate the read meaning of shared addresses from their write meaning.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NUM_MST     = 2;
  localparam int BLK_PER_MST = 7;
  localparam int SRC_W       = BLK_PER_MST + 1;
  localparam int NUM_BLK     = NUM_MST * BLK_PER_MST;
  localparam int NUM_SRC     = NUM_BLK * SRC_W;
  localparam int ADDR_W      = 16;
  localparam int BLK_IDX_W   = $clog2(NUM_BLK);
  localparam int MST_W       = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  localparam int REG_BASE    = 'h100;
  localparam int MST0_OFS    = 'h30;
  localparam int MST_STRIDE  = 'h80;
  localparam int OFS_ROOT    = 0;
  localparam int OFS_CLR     = 1;
  localparam int OFS_MASK    = 8;
  localparam int OFS_RT      = 15;

  typedef enum logic [2:0] {ACC_NONE, ACC_MASTER, ACC_ROOT, ACC_MASK, ACC_RT, ACC_CLR} acc_e;

  typedef struct packed {
    acc_e                 kind;
    logic [MST_W-1:0]     mst;
    logic [BLK_IDX_W-1:0] blk;
  } acc_t;

  function automatic int mst_addr(input int m);
    return REG_BASE + MST0_OFS + m * MST_STRIDE;
  endfunction

  // read meaning of an address
  function automatic acc_t dec_rd(input logic [ADDR_W-1:0] a);
    acc_t r;
    int o;
    r = '{kind: ACC_NONE, mst: '0, blk: '0};
    for (int m = 0; m < NUM_MST; m++) begin
      o = int'(a) - mst_addr(m);
      if (o == 0) begin
        r.kind = ACC_MASTER;
        r.mst  = MST_W'(m);
      end else if (o > OFS_ROOT && o <= OFS_ROOT + BLK_PER_MST) begin
        r.kind = ACC_ROOT;
        r.blk  = BLK_IDX_W'(m * BLK_PER_MST + o - OFS_ROOT - 1);
      end else if (o > OFS_MASK && o <= OFS_MASK + BLK_PER_MST) begin
        r.kind = ACC_MASK;
        r.blk  = BLK_IDX_W'(m * BLK_PER_MST + o - OFS_MASK - 1);
      end else if (o > OFS_RT && o <= OFS_RT + BLK_PER_MST) begin
        r.kind = ACC_RT;
        r.blk  = BLK_IDX_W'(m * BLK_PER_MST + o - OFS_RT - 1);
      end
    end
    return r;
  endfunction

  // write meaning of an address
  function automatic acc_t dec_wr(input logic [ADDR_W-1:0] a);
    acc_t r;
    int o;
    r = '{kind: ACC_NONE, mst: '0, blk: '0};
    for (int m = 0; m < NUM_MST; m++) begin
      o = int'(a) - mst_addr(m);
      if (o > OFS_CLR && o <= OFS_CLR + BLK_PER_MST) begin
        r.kind = ACC_CLR;
        r.blk  = BLK_IDX_W'(m * BLK_PER_MST + o - OFS_CLR - 1);
      end else if (o > OFS_MASK && o <= OFS_MASK + BLK_PER_MST) begin
        r.kind = ACC_MASK;
        r.blk  = BLK_IDX_W'(m * BLK_PER_MST + o - OFS_MASK - 1);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
  import irqagg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output logic [NUM_BLK-1:0] clr_we_o,
  output logic [NUM_BLK-1:0] mask_we_o,
  output acc_t              rd_acc_o
);
  acc_t wa;

  always_comb begin
    wa        = dec_wr(addr_i);
    rd_acc_o  = dec_rd(addr_i);
    clr_we_o  = '0;
    mask_we_o = '0;
    if (wr_i && wa.kind == ACC_CLR)  clr_we_o[wa.blk]  = 1'b1;
    if (wr_i && wa.kind == ACC_MASK) mask_we_o[wa.blk] = 1'b1;
  end

  AST_ONE_WR_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({clr_we_o, mask_we_o})); // R10
  AST_NO_WR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_i |-> ({clr_we_o, mask_we_o} == '0)); // R10
endmodule

// File: rtl/irqagg_block.sv
module irqagg_block #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  output logic [W-1:0] root_o,
  output logic [W-1:0] mask_o,
  output logic         sum_o
);
  logic [W-1:0] raw_q, pend_q, mask_q, rise, clr;

  assign rise = raw_i & ~raw_q;
  assign clr  = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      raw_q  <= raw_i;
      pend_q <= (pend_q & ~clr) | rise;  // new edge beats clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign root_o = pend_q & ~mask_q;
  assign mask_o = mask_q;
  assign sum_o  = |root_o;

  AST_EDGE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R2
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !clr_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_we_i |=> ((pend_q & $past(wdata_i & ~rise)) == '0)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) mask_we_i |=> (mask_o == $past(wdata_i))); // R4
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [SRC_W-1:0]   wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [SRC_W-1:0]   rdata_o,
  output logic               irq_o
);
  logic [NUM_BLK-1:0] clr_we, mask_we, blk_sum;
  logic [SRC_W-1:0]   root_arr [NUM_BLK];
  logic [SRC_W-1:0]   mask_arr [NUM_BLK];
  logic [SRC_W-1:0]   raw_arr  [NUM_BLK];
  logic [SRC_W-1:0]   mst_val  [NUM_MST];
  logic [SRC_W-1:0]   rd_val, rdata_q;
  logic               irq_q;
  acc_t               rd_acc;

  irqagg_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .clr_we_o  (clr_we),
    .mask_we_o (mask_we),
    .rd_acc_o  (rd_acc)
  );

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    assign raw_arr[g] = src_i[g*SRC_W +: SRC_W];
    irqagg_block #(.W(SRC_W)) u_blk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .raw_i     (raw_arr[g]),
      .wdata_i   (wdata_i),
      .clr_we_i  (clr_we[g]),
      .mask_we_i (mask_we[g]),
      .root_o    (root_arr[g]),
      .mask_o    (mask_arr[g]),
      .sum_o     (blk_sum[g])
    );
  end

  // bit 0 of each master carries the next master's summary
  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    if (m == NUM_MST - 1) begin : g_last
      assign mst_val[m] = {blk_sum[m*BLK_PER_MST +: BLK_PER_MST], 1'b0};
    end else begin : g_chain
      assign mst_val[m] = {blk_sum[m*BLK_PER_MST +: BLK_PER_MST], |mst_val[m+1]};
    end
  end

  always_comb begin
    unique case (rd_acc.kind)
      ACC_MASTER: rd_val = mst_val[rd_acc.mst];
      ACC_ROOT:   rd_val = root_arr[rd_acc.blk];
      ACC_MASK:   rd_val = mask_arr[rd_acc.blk];
      ACC_RT:     rd_val = raw_arr[rd_acc.blk];
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_val;
      irq_q <= |mst_val[0];
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (irq_o == $past(blk_sum != '0))); // R9
  AST_CHAIN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni) (mst_val[NUM_MST-1] != '0) |-> mst_val[0][0]); // R8
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_i |=> $stable(rdata_o)); // R12
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (blk_sum == '0) |=> !irq_o); // R9
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [111:0] src = '0;
  logic [15:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [7:0]   rdata;
  logic         irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  irq_aggregator u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .src_i   (src),
    .addr_i  (addr),
    .wdata_i (wdata),
    .wr_i    (wr_en),
    .rd_i    (rd_en),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // R11 mapping: master address for global block g, local block number
  function automatic logic [15:0] maddr(input int n);
    return ((n / 8) / 7 == 0) ? 16'h130 : 16'h1B0;
  endfunction
  function automatic int lblk(input int n);
    return (n / 8) % 7 + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    for (int m = 0; m < 2; m++)
      for (int b = 1; b <= 7; b++) begin
        rd(16'(m ? 'h1B0 : 'h130) + 16'(b + 8), d); check("R1 mask", d, 8'hFF);
        rd(16'(m ? 'h1B0 : 'h130) + 16'(b), d);     check("R1 root", d, 8'h00);
      end

    // masked edge latches but stays hidden (R4, R6)
    @(negedge clk); src[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 masked irq", irq, 0);
    rd(16'h131, d); check("R4 masked root", d, 8'h00);
    rd(16'h140, d); check("R6 rt while masked", d, 8'h08);
    wr(16'h139, 8'h00);
    rd(16'h139, d); check("R4 mask readback", d, 8'h00);
    check("R4 unmasked irq", irq, 1);
    rd(16'h131, d); check("R3 root after unmask", d, 8'h08);
    src[3] = 1'b0;
    wr(16'h132, 8'h08);
    rd(16'h131, d); check("R5 clear", d, 8'h00);

    // unmask everything
    for (int m = 0; m < 2; m++)
      for (int b = 1; b <= 7; b++) wr(16'(m ? 'h1B0 : 'h130) + 16'(b + 8), 8'h00);

    // R11 sweep over every source
    for (int n = 0; n < 112; n++) begin
      automatic logic [15:0] ma = maddr(n);
      automatic int b = lblk(n);
      automatic logic [7:0] bit_v = 8'(1 << (n % 8));
      @(negedge clk); src[n] = 1'b1;
      @(negedge clk); check("R9 irq lag", irq, 0);
      @(negedge clk); check("R2 irq set", irq, 1);
      rd(ma + 16'(b + 15), d); check("R6 rt high", d, bit_v);
      src[n] = 1'b0;
      rd(ma + 16'(b), d); check("R11 root", d, bit_v);
      rd(16'h130, d); check("R8 master0", d, (ma == 16'h130) ? 8'(1 << b) : 8'h01);
      rd(16'h1B0, d); check("R7 master1", d, (ma == 16'h1B0) ? 8'(1 << b) : 8'h00);
      rd(ma + 16'(b + 15), d); check("R6 rt low", d, 8'h00);
      wr(ma + 16'(b + 1), ~bit_v);
      rd(ma + 16'(b), d); check("R5 zero bits kept", d, bit_v);
      wr(ma + 16'(b + 1), bit_v);
      rd(ma + 16'(b), d); check("R5 cleared", d, 8'h00);
      check("R9 irq drop", irq, 0);
    end

    // mask after latch, then unmask (R4, R9)
    @(negedge clk); src[60] = 1'b1;
    @(negedge clk); src[60] = 1'b0;
    wr(16'h1B0 + 16'(1 + 8), 8'h10);
    @(negedge clk); check("R9 masked irq", irq, 0);
    rd(16'h1B1, d); check("R4 masked root", d, 8'h00);
    rd(16'h130, d); check("R8 chain masked", d, 8'h00);
    wr(16'h1B9, 8'h00);
    rd(16'h1B1, d); check("R4 unmask again", d, 8'h10);
    wr(16'h1B2, 8'h10);

    // edge coincides with clear (R5)
    @(negedge clk);
    src[5] = 1'b1; addr = 16'h132; wdata = 8'h20; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(16'h131, d); check("R5 edge beats clear", d, 8'h20);
    wr(16'h132, 8'h20);
    rd(16'h131, d); check("R5 level no relatch", d, 8'h00);
    src[5] = 1'b0;

    // writes to read-only addresses (R10)
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); src[0] = 1'b0;
    wr(16'h131, 8'hFF);
    wr(16'h130, 8'hFF);
    wr(16'h140, 8'hFF);
    wr(16'h000, 8'hFF);
    rd(16'h131, d); check("R10 root kept", d, 8'h01);
    rd(16'h139, d); check("R10 mask kept", d, 8'h00);
    wr(16'h132, 8'h01);
    rd(16'h131, d); check("R5 alias clear", d, 8'h00);

    // R12 unmapped and write-only reads, hold without strobe
    rd(16'h0000, d); check("R12 unmapped", d, 8'h00);
    rd(16'h0138, d); check("R12 clr7 m0", d, 8'h00);
    rd(16'h01B8, d); check("R12 clr7 m1", d, 8'h00);
    rd(16'h01BF, d); check("R12 mask7 m1", d, 8'h00);
    @(negedge clk); src[111] = 1'b1; addr = 16'h1C6;
    @(negedge clk); check("R12 hold", rdata, 8'h00);
    rd(16'h1C6, d); check("R6 rt last", d, 8'h80);
    src[111] = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule